// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the word address pointer of a small serial memory. It also holds a one-page staging buffer that collects write data before the data goes to the array. A bus front end, which is not part of this block, drives it with single-cycle requests. A load request sets the pointer to a byte address. A write step stores one data byte at the pointer and moves the pointer to the next byte. A read step records that one byte was read at the pointer and moves the pointer to the next byte. A commit request, issued at the end of a transaction, sends the staged bytes to the array.

The two kinds of step wrap in different ways. A write step changes only the three low address bits, so the pointer cycles inside an 8-byte page. A read step advances the whole address and rolls over from the top of the array back to zero. The array is either 128 or 256 bytes, chosen by an input pin. The pointer keeps its value between transactions, so a read that gives no address continues at the byte after the last one accessed.

Bytes are staged in an 8-entry buffer, and each entry has a valid bit. If a byte is written again before commit, the new value replaces the old one. A commit starts a burst of eight cycles, one for each page slot. A write strobe goes to the array only for the staged slots. When the burst ends, the valid bits are cleared.

Top module: `page_wrap_pointer`

## Requirements
- R1: After a synchronous reset, `ptr` is 0, `busy` is 0 and `mem_we` is 0.
- R2: A load sets `ptr` to `load_addr`, limited to the configured array size. A load also discards every staged byte, so a later commit writes nothing for those bytes.
- R3: A write step stores `wr_data` in page slot `ptr[2:0]`. It then increments only `ptr[2:0]`, so `ptr` goes from slot 7 back to slot 0 of the same page and `ptr[7:3]` does not change.
- R4: If more than 8 bytes are written before a commit, each slot written again holds only its latest byte, and the commit writes each slot at most once.
- R5: A read step adds one to the full `ptr`. It wraps from 255 to 0 when `big_array`=1, and from 127 to 0 when `big_array`=0.
- R6: When `big_array`=0 (128-byte array), bit 7 of `load_addr` is ignored and `ptr[7]` stays 0.
- R7: A commit with at least one staged byte raises `busy` for 8 cycles. During those cycles page slots 0 to 7 are visited in ascending order. A write is issued (`mem_we`=1, `mem_addr`={page, slot}, `mem_wdata`=staged byte) only for slots that hold a staged byte. A commit with no staged byte does nothing.
- R8: After a burst, no bytes remain staged, so a second commit writes nothing. `ptr` then equals the last written slot plus one, wrapped within the page.
- R9: While `busy` is 1, load, write step, read step and commit have no effect.
- R10: When several requests arrive in the same cycle, only the highest-priority one acts. The order from highest to lowest is: load, write step, read step, commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_array | input | 1 | 1 = 256-byte array, 0 = 128-byte array |
| load | input | 1 | Load the pointer from `load_addr` |
| load_addr | input | 8 | Address to load |
| wr_step | input | 1 | Stage `wr_data` at the pointer, then advance within the page |
| wr_data | input | 8 | Byte to stage |
| rd_step | input | 1 | One byte read; advance across the array |
| commit | input | 1 | Write the staged bytes to the array |
| ptr | output | 8 | Current word address pointer |
| busy | output | 1 | Commit burst in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest situation to create is a page that has been overrun: more than eight bytes written, the pointer having wrapped within the page, and some slots overwritten, all checked through the writes the burst sends to the array. The stimulus loads an address in the middle of the array and sends ten write steps with distinct data. It then checks that the commit sends exactly eight writes, and that the first two slots hold the ninth and tenth bytes. A load and a commit are also sent while a burst is running, to show that requests in that window are ignored.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_WSTEP = 2'd2,
    OP_RSTEP = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/pwp_pointer.sv
module pwp_pointer
  import pwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_array,
  input  ptr_op_e           op,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [ADDR_W-1:0] size_mask;
  logic [PAGE_W-1:0] slot_next;

  assign size_mask = {big_array, {(ADDR_W-1){1'b1}}};
  assign slot_next = ptr_q[PAGE_W-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  ptr_q <= load_addr & size_mask;
        OP_WSTEP: ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], slot_next};
        OP_RSTEP: ptr_q <= (ptr_q + 1'b1) & size_mask;
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

  // R3: write step keeps the page bits
  a_r3_page_hold: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WSTEP) |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));
  // R5: read step at top of array wraps to zero
  a_r5_read_wrap: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RSTEP && ptr_q == size_mask) |=> (ptr_q == '0));
  // R6: small array never sets the top bit on load
  a_r6_small_msb: assert property (@(posedge clk) disable iff (rst)
    (!big_array && op == OP_LOAD) |=> !ptr_q[ADDR_W-1]);
endmodule

// File: rtl/pwp_stage.sv
module pwp_stage
  import pwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ptr_op_e           op,
  input  logic              commit_go,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy_q,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] slot_mem [SLOTS];
  logic [SLOTS-1:0]  valid_q;
  logic [HI_W-1:0]   page_q;
  logic [PAGE_W-1:0] scan_q;
  logic [PAGE_W-1:0] wslot;

  assign wslot = ptr[PAGE_W-1:0];

  // staging storage, no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (op == OP_WSTEP) slot_mem[wslot] <= wr_data;
    mem_wdata <= slot_mem[scan_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      page_q   <= '0;
      scan_q   <= '0;
      busy_q   <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy_q) begin
        mem_we   <= valid_q[scan_q];
        mem_addr <= {page_q, scan_q};
        scan_q   <= scan_q + 1'b1;
        if (scan_q == PAGE_W'(SLOTS - 1)) begin
          busy_q  <= 1'b0;
          valid_q <= '0;
        end
      end else if (op == OP_LOAD) begin
        valid_q <= '0;
      end else if (op == OP_WSTEP) begin
        valid_q[wslot] <= 1'b1;
        page_q         <= ptr[ADDR_W-1:PAGE_W];
      end else if (commit_go && (valid_q != '0)) begin
        busy_q <= 1'b1;
        scan_q <= '0;
      end
    end
  end

  // R7: no array write outside a burst
  a_r7_we_in_burst: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !mem_we);
  // R7: empty commit starts nothing
  a_r7_empty_commit: assert property (@(posedge clk) disable iff (rst)
    (commit_go && !busy_q && valid_q == '0) |=> !busy_q);
  // R8: staging emptied when the burst ends
  a_r8_mask_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (valid_q == '0));
endmodule

// File: rtl/page_wrap_pointer.sv
module page_wrap_pointer
  import pwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_array,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_step,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_step,
  input  logic              commit,
  output logic [ADDR_W-1:0] ptr,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  ptr_op_e op;
  logic    commit_go;

  always_comb begin
    op = OP_IDLE;
    if (!busy) begin
      if (load)         op = OP_LOAD;
      else if (wr_step) op = OP_WSTEP;
      else if (rd_step) op = OP_RSTEP;
    end
  end
  assign commit_go = !busy && commit && !load && !wr_step && !rd_step;

  pwp_pointer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst), .big_array(big_array), .op(op),
    .load_addr(load_addr), .ptr_q(ptr)
  );

  pwp_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_stage (
    .clk(clk), .rst(rst), .op(op), .commit_go(commit_go), .ptr(ptr),
    .wr_data(wr_data), .busy_q(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R9: pointer frozen during a burst
  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr));
endmodule

// File: tb/test_page_wrap_pointer.sv
`timescale 1ns/1ps
module test_page_wrap_pointer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic big_array = 1'b1;
  logic load = 1'b0, wr_step = 1'b0, rd_step = 1'b0, commit = 1'b0;
  logic [7:0] load_addr = '0, wr_data = '0;
  logic [7:0] ptr, mem_addr, mem_wdata;
  logic busy, mem_we;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  page_wrap_pointer i_page_wrap_pointer (
    .clk(clk), .rst(rst), .big_array(big_array), .load(load),
    .load_addr(load_addr), .wr_step(wr_step), .wr_data(wr_data),
    .rd_step(rd_step), .commit(commit), .ptr(ptr), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      model[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
    end
  end

  // op: 0 load, 1 write step, 2 read step ; {op, value, expected ptr}
  localparam logic [17:0] VEC [10] = '{
    {2'd0, 8'h3D, 8'h3D},
    {2'd1, 8'hAA, 8'h3E},
    {2'd1, 8'hBB, 8'h3F},
    {2'd1, 8'hCC, 8'h38},
    {2'd2, 8'h00, 8'h39},
    {2'd2, 8'h00, 8'h3A},
    {2'd0, 8'hFE, 8'hFE},
    {2'd2, 8'h00, 8'hFF},
    {2'd2, 8'h00, 8'h00},
    {2'd1, 8'h11, 8'h01}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; request seen at next posedge; returns at following negedge
  task automatic pulse(input logic l, input logic w, input logic r,
                       input logic c, input logic [7:0] v);
    load = l; wr_step = w; rd_step = r; commit = c;
    load_addr = v; wr_data = v;
    @(negedge clk);
    load = 0; wr_step = 0; rd_step = 0; commit = 0;
  endtask

  initial begin
    for (int k = 0; k < 256; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ptr", ptr, 0);
    check("R1 busy", busy, 0);
    check("R1 mem_we", mem_we, 0);

    // table walk: R2 load, R3 page wrap, R5 array wrap
    for (int i = 0; i < 10; i++) begin
      pulse(VEC[i][17:16] == 2'd0, VEC[i][17:16] == 2'd1,
            VEC[i][17:16] == 2'd2, 1'b0, VEC[i][15:8]);
      check(VEC[i][17:16] == 2'd0 ? "R2 load" :
            VEC[i][17:16] == 2'd1 ? "R3 write step" : "R5 read step",
            ptr, VEC[i][7:0]);
    end

    // R7: one staged byte (slot 0 of page 0x00) goes out alone
    pulse(0, 0, 0, 1, 8'h00);
    check("R7 busy after commit", busy, 1);
    repeat (9) @(negedge clk);
    check("R7 single write count", wcount, 1);
    check("R7 written byte", model[8'h00], 8'h11);
    check("R7 busy ends", busy, 0);

    // R8: second commit writes nothing
    pulse(0, 0, 0, 1, 8'h00);
    check("R8 no burst", busy, 0);
    repeat (9) @(negedge clk);
    check("R8 no writes", wcount, 1);

    // R4: ten bytes into page 0x20
    pulse(1, 0, 0, 0, 8'h20);
    for (int j = 0; j < 10; j++) pulse(0, 1, 0, 0, 8'h40 + 8'(j));
    check("R3 ptr after overrun", ptr, 8'h22);
    pulse(0, 0, 0, 1, 8'h00);
    // R9: load during burst ignored
    pulse(1, 0, 0, 0, 8'h90);
    check("R9 load ignored", ptr, 8'h22);
    pulse(0, 0, 0, 1, 8'h00);
    repeat (9) @(negedge clk);
    check("R4 write count", wcount, 9);
    check("R4 slot0 replaced", model[8'h20], 8'h48);
    check("R4 slot1 replaced", model[8'h21], 8'h49);
    check("R4 slot7 kept", model[8'h27], 8'h47);
    check("R8 ptr after commit", ptr, 8'h22);
    check("R9 commit in burst ignored", busy, 0);

    // R2: load discards staged bytes
    pulse(1, 0, 0, 0, 8'h50);
    pulse(0, 1, 0, 0, 8'hA1);
    pulse(1, 0, 0, 0, 8'h60);
    pulse(0, 0, 0, 1, 8'h00);
    repeat (9) @(negedge clk);
    check("R2 staged discarded", wcount, 9);
    check("R2 array untouched", model[8'h50], 8'h00);

    // R10 priority
    pulse(1, 1, 0, 0, 8'h17);
    check("R10 load over write", ptr, 8'h17);
    pulse(0, 1, 1, 0, 8'h33);
    check("R10 write over read", ptr, 8'h10);

    // R6 / R5 small array
    big_array = 1'b0;
    pulse(1, 0, 0, 0, 8'hFF);
    check("R6 msb dropped", ptr, 8'h7F);
    pulse(0, 0, 1, 0, 8'h00);
    check("R5 small wrap", ptr, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule